// File: doc/BRIEF.md
# Control Track Pulse Writer

This block produces the logic-level write timing for a control-track recording channel, one pulse per period. A period starts at an anchor event. In record and mark-record modes the anchor is a one-cycle reference tick. In rewrite mode the anchor is the rising edge of the control signal that was recorded earlier and is now being played back. From each anchor a 16-bit counter counts system clocks. The write pulse rises at one programmed count and falls at a second one. The falling count is taken from one of four timing registers, chosen by the bit being written and a per-bit length flag.

Write-bits reach the block over a valid/ready stream with a single staging slot. `bit_ready` is high exactly when the slot is empty, and a bit transfers on any clock edge where `bit_valid` and `bit_ready` are both high. The producer must hold `bit_valid` and its data until that edge. Each anchor takes the staged bit, if there is one, and the slot empties. When an anchor finds the slot empty, the block writes the previous bit again and raises `underrun` for that period. The `bit_flag` output shows the bit of the period now being written.

Top module: `ctl_pulse_writer`

## Requirements
- R1: After reset `wr_pulse`=0, `bit_flag`=0, `underrun`=0, `bit_ready`=1, and no pulse is produced before the first anchor.
- R2: A write with `cfg_we`=1 and `cfg_addr`=k, for k from 1 to 5, loads timing register k with `cfg_wdata` on that edge. Register 1 holds the rise count. Registers 2 and 3 hold the short and long fall counts for write-bit 0. Registers 4 and 5 hold the short and long fall counts for write-bit 1.
- R3: Take the clock edge that samples the anchor as count 0, with one added for each later edge. In record mode (`mode`=0, and also `mode`=3) the anchor is `ref_tick`=1. `wr_pulse` is high while the count is at least register 1 and below the selected fall count.
- R4: The fall count comes from register 2 (`bit_long`=0) or register 3 (`bit_long`=1) for write-bit 0. For write-bit 1 it comes from register 4 (`bit_long`=0) or register 5 (`bit_long`=1).
- R5: In rewrite mode (`mode`=1) the anchor is a 0-to-1 change of `pb_ctl` between two edges. The rise count is 0, and `ref_tick` has no effect.
- R6: In mark-record mode (`mode`=2) the fall count is always register 3, whatever the bit and length. The rise count is register 1.
- R7: From the anchor edge onward, `bit_flag` equals the write-bit of the current period: 1 while a 0 pulse (write-bit 1) is written, and 0 while a 1 pulse (write-bit 0) is written.
- R8: `bit_ready` goes low after a transfer and returns high after the next anchor. A bit that transfers on the same edge as an anchor is not used by that anchor; it is used by the following one.
- R9: An anchor that finds the slot empty repeats the previous bit and length and sets `underrun` to 1 for that period. The next anchor that takes a staged bit clears it.
- R10: The count holds at 65535 and does not wrap, so `wr_pulse` stays low once the fall count is reached. When the fall count is not above the rise count, no pulse is produced.
- R11: In record mode `pb_ctl` has no effect on the timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode | input | 2 | 0 record, 1 rewrite, 2 mark-record, 3 record |
| cfg_we | input | 1 | Timing register write strobe |
| cfg_addr | input | 3 | Timing register index, 1 to 5 |
| cfg_wdata | input | 16 | Timing register write data |
| ref_tick | input | 1 | One-cycle reference tick |
| pb_ctl | input | 1 | Previously recorded control signal level |
| bit_valid | input | 1 | Write-bit stream valid |
| bit_ready | output | 1 | Write-bit stream ready (staging slot empty) |
| bit_value | input | 1 | Write-bit value |
| bit_long | input | 1 | Selects the long fall timing for this bit |
| wr_pulse | output | 1 | Logic-level control pulse write timing |
| bit_flag | output | 1 | Bit of the period being written |
| underrun | output | 1 | Current period repeats the previous bit |

## Verification
Every result is due a fixed number of edges after its anchor. `bit_flag` and `underrun` settle on the anchor edge itself. `wr_pulse` first reads high after the edge whose count equals the rise value, and it stays high for (fall - rise) samples. `bit_ready` changes on the edge that makes the transfer or consumes the bit. The bench drives inputs on falling edges. It samples on the falling edge after the anchor as count 0 and on each later falling edge as the next count. It then compares the index of the first high sample and the number of high samples against values computed from the programmed registers.

// File: rtl/ctlw_pkg.sv
package ctlw_pkg;
  localparam int TW = 16;
  localparam int NREG = 5;
  localparam int AW = 3;

  typedef enum logic [1:0] {
    MODE_RECORD  = 2'd0,
    MODE_REWRITE = 2'd1,
    MODE_MARK    = 2'd2,
    MODE_RECALT  = 2'd3
  } ctlw_mode_e;
endpackage

// File: rtl/ctlw_timing_regs.sv
module ctlw_timing_regs #(
  parameter int TW = 16,
  parameter int NREG = 5,
  parameter int AW = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cfg_we,
  input  logic [AW-1:0]            cfg_addr,
  input  logic [TW-1:0]            cfg_wdata,
  output logic [NREG:1][TW-1:0]    regs_o
);
  for (genvar k = 1; k <= NREG; k++) begin : g_reg
    logic [TW-1:0] r_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) r_q <= '0;
      else if (cfg_we && cfg_addr == AW'(k)) r_q <= cfg_wdata;
    end
    assign regs_o[k] = r_q;

    assert_reg_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && cfg_addr == AW'(k)) |=> (regs_o[k] == $past(cfg_wdata)));
  end
endmodule

// File: rtl/ctlw_bit_stage.sv
module ctlw_bit_stage (
  input  logic clk,
  input  logic rst_n,
  input  logic anchor,
  input  logic bit_valid,
  output logic bit_ready,
  input  logic bit_value,
  input  logic bit_long,
  output logic cur_bit,
  output logic cur_long,
  output logic underrun
);
  logic full_q, st_bit_q, st_long_q;
  logic accept;

  assign bit_ready = !full_q;
  assign accept = bit_valid && !full_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q    <= 1'b0;
      st_bit_q  <= 1'b0;
      st_long_q <= 1'b0;
      cur_bit   <= 1'b0;
      cur_long  <= 1'b0;
      underrun  <= 1'b0;
    end else begin
      if (anchor) begin
        if (full_q) begin
          cur_bit  <= st_bit_q;
          cur_long <= st_long_q;
          underrun <= 1'b0;
        end else begin
          underrun <= 1'b1;
        end
      end
      if (accept) begin
        st_bit_q  <= bit_value;
        st_long_q <= bit_long;
      end
      if (accept) full_q <= 1'b1;
      else if (anchor) full_q <= 1'b0;
    end
  end

  assert_ready_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_valid && bit_ready) |=> !bit_ready);
  assert_ready_return_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (anchor && !bit_ready) |=> bit_ready);
  assert_underrun_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (anchor && bit_ready) |=> (underrun && cur_bit == $past(cur_bit)
                               && cur_long == $past(cur_long)));
  assert_underrun_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (anchor && !bit_ready) |=> !underrun);
endmodule

// File: rtl/ctlw_period_timer.sv
module ctlw_period_timer #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          anchor,
  input  logic [TW-1:0] rise_cnt,
  input  logic [TW-1:0] fall_cnt,
  output logic          wr_pulse
);
  localparam logic [TW-1:0] CNT_MAX = '1;

  logic [TW-1:0] cnt_q;
  logic          active_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      active_q <= 1'b0;
    end else if (anchor) begin
      cnt_q    <= '0;
      active_q <= 1'b1;
    end else if (active_q && cnt_q != CNT_MAX) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign wr_pulse = active_q && (cnt_q >= rise_cnt) && (cnt_q < fall_cnt);

  assert_restart_R3: assert property (@(posedge clk) disable iff (!rst_n)
    anchor |=> (cnt_q == '0 && active_q));
  assert_idle_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !active_q |-> !wr_pulse);
  assert_saturate_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && cnt_q == CNT_MAX && !anchor) |=> (cnt_q == CNT_MAX));
  assert_no_inverted_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (fall_cnt <= rise_cnt) |-> !wr_pulse);
endmodule

// File: rtl/ctl_pulse_writer.sv
module ctl_pulse_writer
  import ctlw_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    mode,
  input  logic          cfg_we,
  input  logic [AW-1:0] cfg_addr,
  input  logic [TW-1:0] cfg_wdata,
  input  logic          ref_tick,
  input  logic          pb_ctl,
  input  logic          bit_valid,
  output logic          bit_ready,
  input  logic          bit_value,
  input  logic          bit_long,
  output logic          wr_pulse,
  output logic          bit_flag,
  output logic          underrun
);
  logic [NREG:1][TW-1:0] regs;
  logic pb_q, pb_rise, anchor;
  logic cur_bit, cur_long;
  logic [TW-1:0] rise_cnt, fall_cnt;
  ctlw_mode_e md;

  assign md = ctlw_mode_e'(mode);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pb_q <= 1'b0;
    else        pb_q <= pb_ctl;
  end
  assign pb_rise = pb_ctl && !pb_q;
  assign anchor  = (md == MODE_REWRITE) ? pb_rise : ref_tick;

  ctlw_timing_regs #(.TW(TW), .NREG(NREG), .AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .regs_o(regs)
  );

  ctlw_bit_stage u_stage (
    .clk(clk), .rst_n(rst_n), .anchor(anchor),
    .bit_valid(bit_valid), .bit_ready(bit_ready),
    .bit_value(bit_value), .bit_long(bit_long),
    .cur_bit(cur_bit), .cur_long(cur_long), .underrun(underrun)
  );

  always_comb begin
    rise_cnt = (md == MODE_REWRITE) ? '0 : regs[1];
    if (md == MODE_MARK)       fall_cnt = regs[3];
    else if (!cur_bit)         fall_cnt = cur_long ? regs[3] : regs[2];
    else                       fall_cnt = cur_long ? regs[5] : regs[4];
  end

  ctlw_period_timer #(.TW(TW)) u_timer (
    .clk(clk), .rst_n(rst_n), .anchor(anchor),
    .rise_cnt(rise_cnt), .fall_cnt(fall_cnt), .wr_pulse(wr_pulse)
  );

  assign bit_flag = cur_bit;

  assert_flag_tracks_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (anchor && !bit_ready) |=> (bit_flag == $past(u_stage.st_bit_q)));
endmodule

// File: tb/ctl_pulse_writer_tb.sv
module ctl_pulse_writer_tb;
  logic clk = 0, rst_n = 0;
  logic [1:0] mode = 0;
  logic cfg_we = 0;
  logic [2:0] cfg_addr = 0;
  logic [15:0] cfg_wdata = 0;
  logic ref_tick = 0, pb_ctl = 0, bit_valid = 0, bit_value = 0, bit_long = 0;
  logic bit_ready, wr_pulse, bit_flag, underrun;
  int checks = 0, failures = 0;
  int first_idx, width;
  logic flag0, und0;
  int r1 = 4, r2 = 10, r3 = 20, r4 = 14, r5 = 30;

  always #10 clk = ~clk;

  ctl_pulse_writer u_dut (
    .clk(clk), .rst_n(rst_n), .mode(mode), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .ref_tick(ref_tick), .pb_ctl(pb_ctl),
    .bit_valid(bit_valid), .bit_ready(bit_ready), .bit_value(bit_value),
    .bit_long(bit_long), .wr_pulse(wr_pulse), .bit_flag(bit_flag), .underrun(underrun)
  );

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr_reg(int a, int d);
    @(negedge clk); cfg_we = 1; cfg_addr = 3'(a); cfg_wdata = 16'(d);
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic send_bit(logic v, logic l);
    @(negedge clk); bit_valid = 1; bit_value = v; bit_long = l;
    @(negedge clk); bit_valid = 0;
  endtask

  // anchor: returns at the falling edge where the count is 0
  task automatic anchor_ev(bit use_pb);
    @(negedge clk);
    if (use_pb) pb_ctl = 1; else ref_tick = 1;
    @(negedge clk);
    ref_tick = 0;
  endtask

  // disturb: 1 = ref tick at count 5, 2 = pb rise at count 5
  task automatic measure(int len, int disturb);
    first_idx = -1; width = 0;
    flag0 = bit_flag; und0 = underrun;
    for (int n = 0; n < len; n++) begin
      if (wr_pulse) begin
        if (first_idx < 0) first_idx = n;
        width++;
      end
      @(negedge clk);
      if (n == 4 && disturb == 1) ref_tick = 1;
      if (n == 4 && disturb == 2) pb_ctl = 1;
      if (n == 5) begin ref_tick = 0; pb_ctl = 0; end
    end
    pb_ctl = 0;
  endtask

  task automatic t_reset;
    check("R1 wr_pulse", wr_pulse, 0);
    check("R1 bit_flag", bit_flag, 0);
    check("R1 underrun", underrun, 0);
    check("R1 bit_ready", bit_ready, 1);
    repeat (10) @(negedge clk);
    check("R1 no pulse before anchor", wr_pulse, 0);
  endtask

  task automatic t_program;
    wr_reg(1, r1); wr_reg(2, r2); wr_reg(3, r3); wr_reg(4, r4); wr_reg(5, r5);
  endtask

  task automatic t_record_all;
    for (int b = 0; b < 2; b++)
      for (int l = 0; l < 2; l++) begin
        int f;
        f = (b == 0) ? (l ? r3 : r2) : (l ? r5 : r4);
        send_bit(b[0], l[0]);
        anchor_ev(0);
        measure(40, 0);
        check("R3 rise index", first_idx, r1);
        check("R4 width", width, f - r1);
        check("R7 bit_flag", flag0, b);
        check("R2 regs used", und0, 0);
      end
  endtask

  task automatic t_stream;
    send_bit(1, 0);
    check("R8 ready low when full", bit_ready, 0);
    anchor_ev(0);
    check("R8 ready after anchor", bit_ready, 1);
    measure(40, 0);
    check("R8 bit used", flag0, 1);
    // bit presented on the same edge as an anchor waits for the next one
    @(negedge clk); bit_valid = 1; bit_value = 0; bit_long = 1; ref_tick = 1;
    @(negedge clk); bit_valid = 0; ref_tick = 0;
    check("R8 same-edge bit staged", bit_ready, 0);
    check("R9 same-edge anchor underrun", underrun, 1);
    check("R9 same-edge repeat bit", bit_flag, 1);
    anchor_ev(0);
    measure(40, 0);
    check("R8 staged bit later", flag0, 0);
    check("R8 staged width", width, r3 - r1);
  endtask

  task automatic t_underrun;
    send_bit(1, 1);
    anchor_ev(0); measure(40, 0);
    check("R9 normal period", und0, 0);
    anchor_ev(0); measure(40, 0);
    check("R9 underrun set", und0, 1);
    check("R9 repeat bit", flag0, 1);
    check("R9 repeat length", width, r5 - r1);
    send_bit(0, 0);
    anchor_ev(0); measure(40, 0);
    check("R9 underrun cleared", und0, 0);
    check("R9 new width", width, r2 - r1);
  endtask

  task automatic t_rewrite;
    mode = 1;
    send_bit(1, 0);
    anchor_ev(0); // ref tick ignored in rewrite
    check("R5 ref ignored (slot kept)", bit_ready, 0);
    anchor_ev(1);
    measure(40, 1);
    check("R5 rise at anchor", first_idx, 0);
    check("R5 width", width, r4);
    check("R5 bit", flag0, 1);
    mode = 0;
  endtask

  task automatic t_record_ignores_pb;
    send_bit(0, 1);
    anchor_ev(0);
    measure(40, 2);
    check("R11 rise", first_idx, r1);
    check("R11 width", width, r3 - r1);
  endtask

  task automatic t_mark;
    mode = 2;
    send_bit(0, 0);
    anchor_ev(0); measure(40, 0);
    check("R6 bit0 short uses reg3", width, r3 - r1);
    check("R6 rise", first_idx, r1);
    send_bit(1, 1);
    anchor_ev(0); measure(40, 0);
    check("R6 bit1 long uses reg3", width, r3 - r1);
    mode = 0;
  endtask

  task automatic t_limits;
    wr_reg(2, 3);
    send_bit(0, 0);
    anchor_ev(0); measure(40, 0);
    check("R10 fall below rise gives no pulse", width, 0);
    wr_reg(1, 16'hFFF0); wr_reg(5, 16'hFFFF);
    send_bit(1, 1);
    anchor_ev(0); measure(65560, 0);
    check("R10 saturating rise", first_idx, 16'hFFF0);
    check("R10 saturating width", width, 15);
  endtask

  initial begin
    #1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_program();
    t_record_all();
    t_stream();
    t_underrun();
    t_rewrite();
    t_record_ignores_pb();
    t_mark();
    t_limits();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    failures++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule